// File: doc/BRIEF.md
# Configuration Register Write Guard

This block holds a small bank of configuration words behind a plain synchronous register bus. Each bus cycle carries a word address, a write strobe and 32 bits of write data, and read data comes back in the same cycle. Writes to the protected words are refused unless a 16-bit key register currently holds the value 4758h. Software writes the key, then updates the protected words, then writes any other value to the key to close the bank again. The bank stays closed from reset onward until the key is written.

Address map, in word addresses: address 0 is the key register. It is never protected. Addresses 1 to NPROT are the protected words, which are general configuration, timing, output, start offsets, line delta, buffer size and horizontal and vertical timing; the default is eight of them. Address NPROT+1 is a scratch word that is always writable. Every other address reads zero and ignores writes. All protected words are driven out in parallel on `prot_q`, with word i at bits [32*i+31:32*i] holding address i+1, so downstream logic can use them.

The lock is a two-state machine with the states LOCKED and UNLOCKED. From reset it is in LOCKED. The transition UNLOCK (LOCKED to UNLOCKED) is taken when the key register is written with low half 4758h. The transition RELOCK (UNLOCKED to LOCKED) is taken when the key register is written with any other low half. A key write of 4758h while already UNLOCKED keeps the state. Every other bus cycle holds the state.

Top module: `cfg_guard`

## Requirements
- R1: After reset the key register reads 00000000h, every protected word and the scratch word read 0, and `prot_q` is all zero.
- R2: A key write stores only bits [15:0]. A key read returns that value in bits [15:0] with bits [31:16] reading zero. The state machine looks at the low half only, so FFFF4758h unlocks.
- R3: In state UNLOCKED, a write to a protected address replaces that word. Writing 4758h again keeps the bank UNLOCKED.
- R4: In state LOCKED, a write to a protected address is dropped and the word keeps its earlier value. The bus cycle still completes.
- R5: Writing any value whose low half is not 4758h to the key register re-engages the lock, and later protected writes are dropped.
- R6: A key write changes the lock state at its own clock edge, so it governs the protected writes of later cycles only. A protected write in the very next cycle already sees the new state.
- R7: Protected words read back over the bus in either lock state, and `prot_q` always equals the stored words.
- R8: The scratch word at address NPROT+1 accepts writes in either lock state.
- R9: Unmapped addresses read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (5) | Word address |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, same cycle |
| prot_q | output | NPROT*DATA_W (256) | All protected words, word i at bits [32*i+31:32*i] |

## Verification
The two functions that meet are the lock-state update and the gating of a protected write. The state changes at the edge where the key write lands, and the write-enable check at the very next edge must already use the new state.

The bench provokes this with back-to-back cycles in both directions:
- a key write of 4758h followed at once by a protected write, which must be stored;
- a wrong key followed at once by a protected write, which must be dropped.

Each outcome is judged by reading the word back over the bus and on `prot_q`.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
    localparam int KEY_W = 16;
    localparam logic [KEY_W-1:0] KEY_VAL = 16'h4758;

    typedef enum logic {
        LOCKED   = 1'b0,
        UNLOCKED = 1'b1
    } lock_state_t;
endpackage

// File: rtl/cfg_guard_lock.sv
module cfg_guard_lock
    import cfg_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_wdata,
    output logic [KEY_W-1:0] key_q,
    output lock_state_t      lock_st,
    output logic             wr_ok
);
    lock_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
        end else if (key_wr) begin
            key_q <= key_wdata;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LOCKED:   if (key_wr && key_wdata == KEY_VAL) st_d = UNLOCKED;
            UNLOCKED: if (key_wr && key_wdata != KEY_VAL) st_d = LOCKED;
            default:  st_d = LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= LOCKED;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q)
            LOCKED:   wr_ok = 1'b0;
            UNLOCKED: wr_ok = 1'b1;
            default:  wr_ok = 1'b0;
        endcase
        lock_st = st_q;
    end
endmodule

// File: rtl/cfg_guard_bank.sv
module cfg_guard_bank #(
    parameter int DATA_W = 32,
    parameter int NPROT  = 8,
    parameter int IDX_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    prot_we,
    input  logic [IDX_W-1:0]        prot_idx,
    input  logic                    wr_ok,
    input  logic                    scr_we,
    input  logic [DATA_W-1:0]       wdata,
    output logic [NPROT*DATA_W-1:0] prot_q,
    output logic [DATA_W-1:0]       scr_q
);
    for (genvar i = 0; i < NPROT; i++) begin : g_word
        logic [DATA_W-1:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (prot_we && wr_ok && prot_idx == IDX_W'(i)) begin
                word_q <= wdata;
            end
        end

        assign prot_q[i*DATA_W +: DATA_W] = word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scr_q <= '0;
        end else if (scr_we) begin
            scr_q <= wdata;
        end
    end
endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
    import cfg_guard_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NPROT  = 8,
    parameter int ADDR_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_we,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic [NPROT*DATA_W-1:0] prot_q
);
    localparam int IDX_W = (NPROT > 1) ? $clog2(NPROT) : 1;
    localparam logic [ADDR_W-1:0] KEY_ADDR = '0;
    localparam logic [ADDR_W-1:0] PROT_LO  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PROT_HI  = ADDR_W'(NPROT);
    localparam logic [ADDR_W-1:0] SCR_ADDR = ADDR_W'(NPROT + 1);

    logic              key_hit, prot_hit, scr_hit;
    logic [ADDR_W-1:0] addr_m1;
    logic [IDX_W-1:0]  prot_idx;
    logic [KEY_W-1:0]  key_q;
    logic [DATA_W-1:0] scr_q;
    logic              wr_ok;
    lock_state_t       lock_st;

    always_comb begin
        key_hit  = (bus_addr == KEY_ADDR);
        prot_hit = (bus_addr >= PROT_LO) && (bus_addr <= PROT_HI);
        scr_hit  = (bus_addr == SCR_ADDR);
        addr_m1  = bus_addr - PROT_LO;
        prot_idx = addr_m1[IDX_W-1:0];
    end

    cfg_guard_lock u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (bus_we && key_hit),
        .key_wdata (bus_wdata[KEY_W-1:0]),
        .key_q     (key_q),
        .lock_st   (lock_st),
        .wr_ok     (wr_ok)
    );

    cfg_guard_bank #(
        .DATA_W (DATA_W),
        .NPROT  (NPROT),
        .IDX_W  (IDX_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .prot_we  (bus_we && prot_hit),
        .prot_idx (prot_idx),
        .wr_ok    (wr_ok),
        .scr_we   (bus_we && scr_hit),
        .wdata    (bus_wdata),
        .prot_q   (prot_q),
        .scr_q    (scr_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (key_hit) begin
            bus_rdata[KEY_W-1:0] = key_q;
        end else if (prot_hit) begin
            bus_rdata = prot_q[prot_idx*DATA_W +: DATA_W];
        end else if (scr_hit) begin
            bus_rdata = scr_q;
        end
    end
endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk
    import cfg_guard_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NPROT  = 8,
    parameter int ADDR_W = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic                    bus_we,
    input logic [DATA_W-1:0]       bus_wdata,
    input logic [DATA_W-1:0]       bus_rdata,
    input logic [NPROT*DATA_W-1:0] prot_q,
    input logic [KEY_W-1:0]        key_q,
    input lock_state_t             lock_st
);
    logic key_wr;
    assign key_wr = bus_we && (bus_addr == '0);

    AST_KEY_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> (bus_rdata[DATA_W-1:KEY_W] == '0)); // R2

    AST_UNLOCK_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && bus_wdata[KEY_W-1:0] == KEY_VAL) |=> (lock_st == UNLOCKED)); // R3

    AST_STATE_TRACKS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        ((lock_st == UNLOCKED) == (key_q == KEY_VAL))); // R3

    AST_LOCKED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_st == LOCKED) |=> $stable(prot_q)); // R4

    AST_RELOCK_ON_WRONG: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && bus_wdata[KEY_W-1:0] != KEY_VAL) |=> (lock_st == LOCKED)); // R5

    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |=> $stable(lock_st)); // R6
endmodule

bind cfg_guard cfg_guard_chk #(
    .DATA_W (DATA_W),
    .NPROT  (NPROT),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .prot_q    (prot_q),
    .key_q     (key_q),
    .lock_st   (lock_st)
);

// File: tb/cfg_guard_tb.sv
module cfg_guard_tb;
    localparam int CLK_P  = 10;
    localparam int DATA_W = 32;
    localparam int NPROT  = 8;
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] SCR = ADDR_W'(NPROT + 1);

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [ADDR_W-1:0]       bus_addr = '0;
    logic                    bus_we = 1'b0;
    logic [DATA_W-1:0]       bus_wdata = '0;
    logic [DATA_W-1:0]       bus_rdata;
    logic [NPROT*DATA_W-1:0] prot_q;

    int n_chk = 0;
    int n_fail = 0;
    logic [DATA_W-1:0] exp_w [NPROT];
    logic [DATA_W-1:0] exp_scr;

    always #(CLK_P/2) clk = ~clk;

    cfg_guard #(.DATA_W(DATA_W), .NPROT(NPROT), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .prot_q(prot_q)
    );

    task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic check_all(input string tag);
        logic [DATA_W-1:0] v;
        for (int i = 0; i < NPROT; i++) begin
            rd(ADDR_W'(i + 1), v);
            check(tag, v, exp_w[i]);
            check({tag, " prot_q R7"}, prot_q[i*DATA_W +: DATA_W], exp_w[i]);
        end
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] v;
        rd('0, v);
        check("R1 key after reset", v, '0);
        rd(SCR, v);
        check("R1 scratch after reset", v, '0);
        check_all("R1 protected after reset");
        wr(ADDR_W'(1), 32'hDEAD_0001);
        check_all("R1 R4 write while locked out of reset");
    endtask

    task automatic t_unlock();
        logic [DATA_W-1:0] v;
        wr('0, 32'h0000_4758);
        wr(ADDR_W'(1), 32'hA5A5_0001);
        exp_w[0] = 32'hA5A5_0001;
        rd('0, v);
        check("R2 key readback", v, 32'h0000_4758);
        check_all("R3 R6 write right after unlock");
    endtask

    task automatic t_upper_bits();
        logic [DATA_W-1:0] v;
        wr('0, 32'h1234_0000);
        wr('0, 32'hFFFF_4758);
        rd('0, v);
        check("R2 key upper bits read zero", v, 32'h0000_4758);
        wr(ADDR_W'(3), 32'h0303_0303);
        exp_w[2] = 32'h0303_0303;
        wr('0, 32'h0000_4758);
        wr(ADDR_W'(NPROT), 32'h0808_0808);
        exp_w[NPROT-1] = 32'h0808_0808;
        check_all("R2 R3 unlock by low half, rekey stays open");
    endtask

    task automatic t_relock();
        wr('0, 32'h0000_1234);
        wr(ADDR_W'(1), 32'hBAD0_0001);
        check_all("R5 R6 write right after wrong key dropped");
        wr(ADDR_W'(3), 32'hBAD0_0003);
        check_all("R5 R7 later write dropped, words readable");
    endtask

    task automatic t_drop_all();
        for (int i = 0; i < NPROT; i++) wr(ADDR_W'(i + 1), 32'hFFFF_FFFF);
        check_all("R4 all protected writes dropped while locked");
    endtask

    task automatic t_scratch();
        logic [DATA_W-1:0] v;
        wr(SCR, 32'h5C5C_0001);
        rd(SCR, v);
        check("R8 scratch writable while locked", v, 32'h5C5C_0001);
        wr('0, 32'h0000_4758);
        wr(SCR, 32'h5C5C_0002);
        rd(SCR, v);
        check("R8 scratch writable while unlocked", v, 32'h5C5C_0002);
        exp_scr = 32'h5C5C_0002;
    endtask

    task automatic t_unmapped();
        logic [DATA_W-1:0] v;
        wr(ADDR_W'(31), 32'h7777_7777);
        wr(ADDR_W'(NPROT + 2), 32'h6666_6666);
        rd(ADDR_W'(31), v);
        check("R9 unmapped reads zero", v, '0);
        rd(ADDR_W'(NPROT + 2), v);
        check("R9 unmapped reads zero", v, '0);
        rd(SCR, v);
        check("R9 scratch untouched", v, exp_scr);
        rd('0, v);
        check("R9 key untouched", v, 32'h0000_4758);
        check_all("R9 protected untouched");
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NPROT; i++) exp_w[i] = '0;
        exp_scr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_unlock();
        t_upper_bits();
        t_relock();
        t_drop_all();
        t_scratch();
        t_unmapped();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule